// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block tracks exception conditions for a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Each stage that can detect a fault reports it on a sideband input while the offending instruction occupies that stage. The unit stores the condition in a small shadow pipeline beside the instruction's PC. Nothing is acted on until the instruction reaches the memory stage, which is the commit point. There, one fault code is chosen by a fixed priority. An external interrupt request is also merged in at that point.

When a fault or interrupt is taken, the unit does the following:
- writes the cause code and the exception PC;
- clears every younger tracked instruction;
- withholds writeback from the faulting instruction;
- raises a one-cycle redirect to a fixed handler address;
- disables interrupts and enters kernel mode.

A return-from-exception instruction reaching commit reverses the mode change and redirects fetch to the saved exception PC. The datapath observes the redirect pulse. It uses that pulse to discard its own younger stage contents and to steer the program counter.

Top module: `exc_commit_unit`

## Requirements
- R1: While `rst` is high and after it, until the first commit: `cause` = 0, `epc` = 0, `int_enable` = 0, `kernel_mode` = 1, `redirect_valid` = 0, `wb_valid` = 0.
- R2: A fault reported for an instruction takes effect only at its commit. An instruction fetched in cycle t commits at the clock edge closing cycle t+3, and the redirect and new cause are visible right after that edge. Every older instruction writes back before it, in program order, with `wb_pc` equal to its fetch PC.
- R3: Cause codes are 0 none, 1 fetch address fault, 2 illegal opcode, 3 arithmetic overflow, 4 data address fault, 8 external interrupt. When one instruction collects several faults, the one raised in the earliest stage is recorded.
- R4: `ext_irq` is honoured only while `int_enable` is 1 and a valid instruction is at commit. It then overrides any synchronous fault of that instruction with code 8. While interrupts are disabled it has no effect.
- R5: On a taken exception, `cause` and `epc` (the faulting instruction's PC) are written. `redirect_valid` pulses for exactly one cycle with `redirect_pc` equal to the handler parameter. The faulting instruction does not write back.
- R6: Instructions younger than a committed exception or return are killed. They never write back and never change `cause` or `epc`, even when they carry faults. The fetch input offered during the redirect cycle is discarded.
- R7: Taking an exception or interrupt clears `int_enable` and sets `kernel_mode`.
- R8: A return-from-exception instruction at commit with no fault of its own does the following: sets `int_enable`, clears `kernel_mode`, writes back, and redirects to the current `epc`. If the same instruction carries a fault, the exception is taken instead.
- R9: `cause` and `epc` change only in a cycle that shows an exception redirect. Normal retirement and killed instructions leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An instruction is fetched this cycle |
| fetch_pc | input | PC_W | PC of the fetched instruction |
| fetch_fault | input | 1 | Fetch address fault for the fetched instruction |
| dec_illegal | input | 1 | Illegal opcode for the instruction in decode |
| exe_overflow | input | 1 | Overflow for the instruction in execute |
| mem_fault | input | 1 | Data address fault for the instruction in memory |
| mem_rfe | input | 1 | Instruction in memory is a return-from-exception |
| ext_irq | input | 1 | External interrupt request |
| wb_valid | output | 1 | An instruction retires into writeback this cycle |
| wb_pc | output | PC_W | PC of the retiring instruction |
| cause | output | 4 | Cause code of the last taken exception |
| epc | output | PC_W | PC of the last excepting instruction |
| int_enable | output | 1 | Interrupts enabled |
| kernel_mode | output | 1 | Privileged mode |
| redirect_valid | output | 1 | One-cycle fetch redirect and kill of younger stages |
| redirect_pc | output | PC_W | Target of the redirect |

## Verification
Suppose a fault bit is lost or a wrong fault bit is kept in the shadow pipeline. The result appears at the ports three cycles after the fetch: `cause` holds a wrong code, or the redirect fires on the wrong instruction. The number and order of `wb_pc` values before the redirect then also differ from program order. Suppose instead the younger entries are not cleared on a flush. Then a killed instruction writes back, or rewrites `cause` and `epc`, within three cycles of the redirect. A corrupted mode bit only becomes visible at the next interrupt request or the next return. For that reason the scenarios chain a return, an enabled interrupt and a masked interrupt back to back.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [3:0] {
    CAUSE_NONE     = 4'd0,
    CAUSE_FETCH    = 4'd1,
    CAUSE_ILLEGAL  = 4'd2,
    CAUSE_OVERFLOW = 4'd3,
    CAUSE_DATA     = 4'd4,
    CAUSE_IRQ      = 4'd8
  } cause_e;

  // Keep an earlier-stage fault; otherwise record the newly raised one.
  function automatic cause_e merge_fault(cause_e held, logic raise, cause_e code);
    if (held != CAUSE_NONE) return held;
    return raise ? code : CAUSE_NONE;
  endfunction

endpackage

// File: rtl/exc_stage.sv
module exc_stage
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            in_valid,
  input  logic [PC_W-1:0] in_pc,
  input  cause_e          in_cause,
  output logic            q_valid,
  output logic [PC_W-1:0] q_pc,
  output cause_e          q_cause
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_pc    <= '0;
      q_cause <= CAUSE_NONE;
    end else begin
      q_valid <= in_valid & ~flush;
      q_pc    <= in_pc;
      q_cause <= in_cause;
    end
  end

endmodule

// File: rtl/exc_commit_arbiter.sv
module exc_commit_arbiter
  import exc_pkg::*;
(
  input  logic   m_valid,
  input  cause_e m_cause,
  input  logic   mem_fault,
  input  logic   mem_rfe,
  input  logic   ext_irq,
  input  logic   int_en,
  output logic   take_exc,
  output logic   take_rfe,
  output logic   retire,
  output cause_e final_cause
);

  logic   take_irq;
  cause_e sync_cause;

  always_comb begin
    take_irq    = m_valid & ext_irq & int_en;
    sync_cause  = merge_fault(m_cause, mem_fault, CAUSE_DATA);
    final_cause = take_irq ? CAUSE_IRQ : sync_cause;
    take_exc    = m_valid & (final_cause != CAUSE_NONE);
    take_rfe    = m_valid & mem_rfe & ~take_exc;
    retire      = m_valid & ~take_exc;
  end

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_exc,
  input  logic            take_rfe,
  input  logic            retire,
  input  cause_e          final_cause,
  input  logic [PC_W-1:0] m_pc,
  output logic [3:0]      cause_q,
  output logic [PC_W-1:0] epc_q,
  output logic            ie_q,
  output logic            kern_q,
  output logic            redir_q,
  output logic [PC_W-1:0] redir_pc_q,
  output logic            wb_valid_q,
  output logic [PC_W-1:0] wb_pc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q    <= 4'd0;
      epc_q      <= '0;
      ie_q       <= 1'b0;
      kern_q     <= 1'b1;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
      wb_valid_q <= 1'b0;
      wb_pc_q    <= '0;
    end else begin
      redir_q    <= take_exc | take_rfe;
      wb_valid_q <= retire;
      wb_pc_q    <= m_pc;
      if (take_exc) begin
        cause_q    <= final_cause;
        epc_q      <= m_pc;
        ie_q       <= 1'b0;
        kern_q     <= 1'b1;
        redir_pc_q <= HANDLER_PC;
      end else if (take_rfe) begin
        ie_q       <= 1'b1;
        kern_q     <= 1'b0;
        redir_pc_q <= epc_q;
      end
    end
  end

endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
  import exc_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            fetch_fault,
  input  logic            dec_illegal,
  input  logic            exe_overflow,
  input  logic            mem_fault,
  input  logic            mem_rfe,
  input  logic            ext_irq,
  output logic            wb_valid,
  output logic [PC_W-1:0] wb_pc,
  output logic [3:0]      cause,
  output logic [PC_W-1:0] epc,
  output logic            int_enable,
  output logic            kernel_mode,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc
);

  // Shadow stages: 0 = decode, 1 = execute, 2 = memory (commit point).
  localparam int NSTG = 3;
  localparam int MIDX = NSTG - 1;

  logic            st_valid [NSTG];
  logic [PC_W-1:0] st_pc    [NSTG];
  cause_e          st_cause [NSTG];

  logic            nx_valid [NSTG];
  logic [PC_W-1:0] nx_pc    [NSTG];
  cause_e          nx_cause [NSTG];

  // Fault raised for the instruction entering stage s, and its code.
  logic   [NSTG-1:0] raise;
  cause_e            code [NSTG];

  logic   take_exc, take_rfe, retire, flush;
  cause_e final_cause;

  assign raise   = {exe_overflow, dec_illegal, fetch_fault};
  assign code[0] = CAUSE_FETCH;
  assign code[1] = CAUSE_ILLEGAL;
  assign code[2] = CAUSE_OVERFLOW;
  assign flush   = take_exc | take_rfe;

  generate
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_comb begin
          nx_valid[s] = fetch_valid & ~redirect_valid;
          nx_pc[s]    = fetch_pc;
          nx_cause[s] = merge_fault(CAUSE_NONE, raise[s], code[s]);
        end
      end else begin : g_body
        always_comb begin
          nx_valid[s] = st_valid[s-1];
          nx_pc[s]    = st_pc[s-1];
          nx_cause[s] = merge_fault(st_cause[s-1], raise[s], code[s]);
        end
      end

      exc_stage #(.PC_W(PC_W)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .in_valid(nx_valid[s]),
        .in_pc   (nx_pc[s]),
        .in_cause(nx_cause[s]),
        .q_valid (st_valid[s]),
        .q_pc    (st_pc[s]),
        .q_cause (st_cause[s])
      );
    end
  endgenerate

  exc_commit_arbiter u_arb (
    .m_valid    (st_valid[MIDX]),
    .m_cause    (st_cause[MIDX]),
    .mem_fault  (mem_fault),
    .mem_rfe    (mem_rfe),
    .ext_irq    (ext_irq),
    .int_en     (int_enable),
    .take_exc   (take_exc),
    .take_rfe   (take_rfe),
    .retire     (retire),
    .final_cause(final_cause)
  );

  exc_status_regs #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .take_exc   (take_exc),
    .take_rfe   (take_rfe),
    .retire     (retire),
    .final_cause(final_cause),
    .m_pc       (st_pc[MIDX]),
    .cause_q    (cause),
    .epc_q      (epc),
    .ie_q       (int_enable),
    .kern_q     (kernel_mode),
    .redir_q    (redirect_valid),
    .redir_pc_q (redirect_pc),
    .wb_valid_q (wb_valid),
    .wb_pc_q    (wb_pc)
  );

endmodule

// File: rtl/exc_commit_unit_chk.sv
module exc_commit_unit_chk #(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
  input logic            clk,
  input logic            rst,
  input logic            wb_valid,
  input logic [3:0]      cause,
  input logic [PC_W-1:0] epc,
  input logic            int_enable,
  input logic            kernel_mode,
  input logic            redirect_valid,
  input logic [PC_W-1:0] redirect_pc
);

  AST_LEGAL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (cause inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd8})); // R3

  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !redirect_valid); // R5

  AST_EXC_NO_WB: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && kernel_mode) |-> !wb_valid); // R5

  AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (rst)
    $rose(kernel_mode) |-> (redirect_valid && redirect_pc == HANDLER_PC && !int_enable)); // R7

  AST_RFE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(int_enable) |-> (redirect_valid && !kernel_mode)); // R8

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !redirect_valid |-> ($stable(cause) && $stable(epc))); // R9

endmodule

bind exc_commit_unit exc_commit_unit_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wb_valid      (wb_valid),
  .cause         (cause),
  .epc           (epc),
  .int_enable    (int_enable),
  .kernel_mode   (kernel_mode),
  .redirect_valid(redirect_valid),
  .redirect_pc   (redirect_pc)
);

// File: tb/exc_commit_unit_test.sv
`timescale 1ns/1ps
module exc_commit_unit_test;

  localparam int          PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0080;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_valid = 1'b0, fetch_fault = 1'b0, dec_illegal = 1'b0;
  logic exe_overflow = 1'b0, mem_fault = 1'b0, mem_rfe = 1'b0, ext_irq = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            wb_valid, int_enable, kernel_mode, redirect_valid;
  logic [PC_W-1:0] wb_pc, epc, redirect_pc;
  logic [3:0]      cause;

  int checks = 0;
  int fails  = 0;

  // Per-slot flags: [0] fetch fault, [1] illegal, [2] overflow, [3] data fault, [4] return.
  logic [4:0]  fl [8];
  int          n_slots;
  int          irq_slot;
  logic [31:0] base;

  always #4 clk = ~clk;

  exc_commit_unit #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) uut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_fault(fetch_fault), .dec_illegal(dec_illegal), .exe_overflow(exe_overflow),
    .mem_fault(mem_fault), .mem_rfe(mem_rfe), .ext_irq(ext_irq),
    .wb_valid(wb_valid), .wb_pc(wb_pc), .cause(cause), .epc(epc),
    .int_enable(int_enable), .kernel_mode(kernel_mode),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog(input logic [31:0] b, input int n);
    for (int i = 0; i < 8; i++) fl[i] = 5'b0;
    base = b; n_slots = n; irq_slot = -1;
  endtask

  // Runs the program; returns writebacks seen and the cycle of the first redirect.
  task automatic run_prog(input string req, output int wb_cnt, output int redir_cyc);
    bit stop = 0;
    wb_cnt = 0; redir_cyc = -1;
    for (int c = 0; c < n_slots + 6; c++) begin
      fetch_valid  = !stop && c < n_slots;
      fetch_pc     = base + 32'(4 * c);
      fetch_fault  = fetch_valid && fl[c % 8][0];
      dec_illegal  = (c - 1 >= 0 && c - 1 < n_slots) ? fl[(c - 1) % 8][1] : 1'b0;
      exe_overflow = (c - 2 >= 0 && c - 2 < n_slots) ? fl[(c - 2) % 8][2] : 1'b0;
      mem_fault    = (c - 3 >= 0 && c - 3 < n_slots) ? fl[(c - 3) % 8][3] : 1'b0;
      mem_rfe      = (c - 3 >= 0 && c - 3 < n_slots) ? fl[(c - 3) % 8][4] : 1'b0;
      ext_irq      = (irq_slot == c - 3);
      @(posedge clk);
      @(negedge clk);
      if (wb_valid) begin
        chk(req, "wb_pc order", wb_pc, base + 32'(4 * wb_cnt)); // R2
        wb_cnt++;
      end
      if (redirect_valid && !stop) begin
        stop = 1;
        redir_cyc = c;
      end
    end
    fetch_valid = 0; fetch_fault = 0; dec_illegal = 0; exe_overflow = 0;
    mem_fault = 0; mem_rfe = 0; ext_irq = 0;
  endtask

  task automatic expect_state(input string req, input int wb_cnt, input int redir_cyc,
                              input int exp_wb, input int exp_cyc, input logic [3:0] exp_cause,
                              input logic [31:0] exp_epc, input logic exp_ie, input logic exp_k,
                              input logic [31:0] exp_rpc, input logic chk_rpc);
    chk(req, "writeback count", 32'(wb_cnt), 32'(exp_wb));
    chk(req, "redirect cycle", 32'(redir_cyc), 32'(exp_cyc));
    chk(req, "cause", {28'b0, cause}, {28'b0, exp_cause});
    chk(req, "epc", epc, exp_epc);
    chk(req, "int_enable", {31'b0, int_enable}, {31'b0, exp_ie});
    chk(req, "kernel_mode", {31'b0, kernel_mode}, {31'b0, exp_k});
    if (chk_rpc) chk(req, "redirect_pc", redirect_pc_seen, exp_rpc);
  endtask

  logic [31:0] redirect_pc_seen = '0;
  always @(negedge clk) if (redirect_valid) redirect_pc_seen = redirect_pc;

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "cause", {28'b0, cause}, 32'd0);
    chk("R1", "epc", epc, 32'd0);
    chk("R1", "int_enable", {31'b0, int_enable}, 32'd0);
    chk("R1", "kernel_mode", {31'b0, kernel_mode}, 32'd1);
    chk("R1", "redirect_valid", {31'b0, redirect_valid}, 32'd0);
    chk("R1", "wb_valid", {31'b0, wb_valid}, 32'd0);
  endtask

  task automatic t_clean();
    int w, r;
    clear_prog(32'h1000, 5);
    run_prog("R2", w, r);
    expect_state("R9", w, r, 5, -1, 4'd0, 32'h0, 1'b0, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_fetch_fault();
    int w, r;
    clear_prog(32'h2000, 5); fl[2] = 5'b00001;
    run_prog("R2", w, r);
    expect_state("R5", w, r, 2, 5, 4'd1, 32'h2008, 1'b0, 1'b1, HANDLER, 1'b1);
  endtask

  task automatic t_illegal();
    int w, r;
    clear_prog(32'h3000, 4); fl[1] = 5'b00010;
    run_prog("R2", w, r);
    expect_state("R3", w, r, 1, 4, 4'd2, 32'h3004, 1'b0, 1'b1, HANDLER, 1'b1);
  endtask

  task automatic t_younger_killed();
    int w, r;
    clear_prog(32'h4000, 6); fl[3] = 5'b00100; fl[4] = 5'b00010; fl[5] = 5'b00001;
    run_prog("R6", w, r);
    expect_state("R6", w, r, 3, 6, 4'd3, 32'h400C, 1'b0, 1'b1, HANDLER, 1'b1);
  endtask

  task automatic t_data_fault();
    int w, r;
    clear_prog(32'h5000, 3); fl[0] = 5'b01000;
    run_prog("R5", w, r);
    expect_state("R5", w, r, 0, 3, 4'd4, 32'h5000, 1'b0, 1'b1, HANDLER, 1'b1);
  endtask

  task automatic t_priority();
    int w, r;
    clear_prog(32'h6000, 4); fl[1] = 5'b01101;
    run_prog("R3", w, r);
    expect_state("R3", w, r, 1, 4, 4'd1, 32'h6004, 1'b0, 1'b1, HANDLER, 1'b1);
    clear_prog(32'h6100, 3); fl[0] = 5'b01010;
    run_prog("R3", w, r);
    expect_state("R3", w, r, 0, 3, 4'd2, 32'h6100, 1'b0, 1'b1, HANDLER, 1'b1);
  endtask

  task automatic t_irq_masked();
    int w, r;
    clear_prog(32'h7000, 5); irq_slot = 2;
    run_prog("R4", w, r);
    expect_state("R4", w, r, 5, -1, 4'd2, 32'h6100, 1'b0, 1'b1, 32'h0, 1'b0);
  endtask

  task automatic t_rfe();
    int w, r;
    clear_prog(32'h8000, 4); fl[1] = 5'b10000;
    run_prog("R8", w, r);
    expect_state("R8", w, r, 2, 4, 4'd2, 32'h6100, 1'b1, 1'b0, 32'h6100, 1'b1);
  endtask

  task automatic t_irq_taken();
    int w, r;
    clear_prog(32'h9000, 5); irq_slot = 2; fl[2] = 5'b01000;
    run_prog("R4", w, r);
    expect_state("R7", w, r, 2, 5, 4'd8, 32'h9008, 1'b0, 1'b1, HANDLER, 1'b1);
  endtask

  task automatic t_rfe_with_fault();
    int w, r;
    clear_prog(32'hA000, 3); fl[0] = 5'b11000;
    run_prog("R8", w, r);
    expect_state("R8", w, r, 0, 3, 4'd4, 32'hA000, 1'b0, 1'b1, HANDLER, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_clean();
    t_fetch_fault();
    t_illegal();
    t_younger_killed();
    t_data_fault();
    t_priority();
    t_irq_masked();
    t_rfe();
    t_irq_taken();
    t_rfe_with_fault();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule